// File: doc/BRIEF.md
# Epoch-Based Prefetch Degree Controller

This block sets how aggressive a cache prefetcher is by closing a feedback loop over fixed windows of time. Over each epoch it counts four kinds of single-cycle event: prefetches that turned out useful, prefetches sent, raw cache misses and raw cache hits. At the end of the epoch it turns those counts into three ratios. Accuracy is useful over sent, coverage is useful over misses, and hit ratio is hits over hits plus misses. It compares each ratio against programmable thresholds and moves an internal "useful degree" up or down by one step.

The block also estimates the memory bandwidth the prefetcher is demanding. It takes an estimated request count, multiplies it by a programmable memory latency and divides by the epoch length. The degree it reports is the smaller of that estimate and the useful degree. The prefetch address generator reads this output as the most requests it may launch for one trigger. Every threshold is an unsigned fraction with 10 fractional bits, so 1024 means 1.0. Each comparison is an integer cross-multiplication, and no division is needed to compare a ratio.

Top module: `pf_degree_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `degree` equals START_DEG (default 4), and the useful degree also starts at START_DEG.
- R2: An epoch boundary occurs every max(`epoch_len`,1) cycles, the first one `epoch_len` cycles after reset is released. `degree` changes only in the cycle that follows a boundary.
- R3: Each event input held high in a cycle adds one to its counter. All four counters restart at each boundary. An event pulse in the boundary cycle itself is counted in the new epoch, and the boundary decision uses only the counts from before it.
- R4: At a boundary the useful degree rises by one when coverage is above `thr_cov_hi`/1024 and either accuracy is above `thr_acc_hi`/1024 or hit ratio is below `thr_hit_lo`/1024. This rule takes priority over R5.
- R5: Otherwise the useful degree falls by one in two cases: coverage is below `thr_cov_lo`/1024 together with accuracy below `thr_acc_lo`/1024 or hit ratio above `thr_hit_hi`/1024, or accuracy is below `thr_acc_lo`/1024 together with hit ratio above `thr_hit_hi`/1024.
- R6: A ratio whose denominator is zero counts as neither above nor below any threshold. An epoch with no events therefore leaves the useful degree unchanged.
- R7: The useful degree saturates at MAX_DEG (default 16) and at 1.
- R8: The request estimate is misses + sent − useful, clamped at zero when useful exceeds misses + sent.
- R9: After a boundary, `degree` = min(floor(requests × `mem_lat` / max(`epoch_len`,1)), new useful degree).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_good | input | 1 | A prefetched line was demanded |
| ev_issued | input | 1 | A prefetch was sent |
| ev_miss | input | 1 | Raw cache miss |
| ev_hit | input | 1 | Raw cache hit |
| thr_cov_hi | input | 11 | High coverage threshold, Q10 |
| thr_cov_lo | input | 11 | Low coverage threshold, Q10 |
| thr_acc_hi | input | 11 | High accuracy threshold, Q10 |
| thr_acc_lo | input | 11 | Low accuracy threshold, Q10 |
| thr_hit_hi | input | 11 | High hit-ratio threshold, Q10 |
| thr_hit_lo | input | 11 | Low hit-ratio threshold, Q10 |
| epoch_len | input | 16 | Epoch length in cycles (0 acts as 1) |
| mem_lat | input | 12 | Memory latency used in the bandwidth estimate |
| degree | output | 5 | Effective prefetch degree |

## Verification
The bench aims at the following corner cases.
- **Empty epochs.** If a zero denominator were treated as a real ratio, the degree would drift in an epoch with no events.
- **Useful prefetches alone.** When useful prefetches outnumber misses plus sent prefetches, an estimate that failed to clamp would wrap to a huge number, and the degree would jump to the useful degree instead of falling to 0.
- **Events on the boundary cycle.** A pulse arriving with the boundary would either be lost or leak into the closing decision if the counters cleared wrongly.
- **Saturation.** Long runs of good and bad epochs push the useful degree into both limits, so a missing clamp shows up as a wrap.
- **One-cycle epochs.** Epoch lengths of 0 and 1 make a boundary every cycle.
- **Bandwidth cap.** A small latency makes the cap bind below the useful degree, which exposes an off-by-one in the truncated division.

// File: rtl/pfdc_pkg.sv
package pfdc_pkg;

    localparam int Q_BITS = 10;
    localparam int THR_W  = Q_BITS + 1;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic [THR_W-1:0] cov_hi;
        logic [THR_W-1:0] cov_lo;
        logic [THR_W-1:0] acc_hi;
        logic [THR_W-1:0] acc_lo;
        logic [THR_W-1:0] hit_hi;
        logic [THR_W-1:0] hit_lo;
    } thr_t;

    typedef struct packed {
        logic good;
        logic issued;
        logic miss;
        logic hit;
    } ev_t;

    // num/den > thr/2^Q, false when den is zero
    function automatic logic ratio_above(logic [31:0] num, logic [31:0] den,
                                         logic [THR_W-1:0] thr);
        logic [47:0] lhs;
        logic [47:0] rhs;
        lhs = {16'd0, num} << Q_BITS;
        rhs = 48'(thr) * {16'd0, den};
        return (den != 32'd0) && (lhs > rhs);
    endfunction

    // num/den < thr/2^Q, false when den is zero
    function automatic logic ratio_below(logic [31:0] num, logic [31:0] den,
                                         logic [THR_W-1:0] thr);
        logic [47:0] lhs;
        logic [47:0] rhs;
        lhs = {16'd0, num} << Q_BITS;
        rhs = 48'(thr) * {16'd0, den};
        return (den != 32'd0) && (lhs < rhs);
    endfunction

endpackage

// File: rtl/pfdc_epoch_timer.sv
module pfdc_epoch_timer #(
    parameter int EPOCH_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [EPOCH_W-1:0] epoch_len,
    output logic               strobe
);
    logic [EPOCH_W-1:0] cnt;

    // boundary when the cycle count reaches the programmed length (0 acts as 1)
    assign strobe = ({1'b0, cnt} + 1'b1) >= {1'b0, epoch_len};

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (strobe) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    // R2: the count never passes the programmed length while it stays fixed
    assert_epoch_bound_R2: assert property (@(posedge clk) disable iff (rst)
        $stable(epoch_len) && !$past(strobe) |-> ({1'b0, cnt} < ({1'b0, epoch_len} + 1'b1)));

endmodule

// File: rtl/pfdc_evt_counter.sv
module pfdc_evt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (clear)
            count <= CNT_W'(inc);   // boundary-cycle pulse opens the new epoch
        else if (inc && count != CNT_MAX)
            count <= count + 1'b1;
    end

    // R3: a boundary leaves at most the one pulse of its own cycle
    assert_cleared_at_epoch_R3: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count <= CNT_W'(1)));

    // R3: outside a boundary a counter moves by at most one
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/pfdc_ratio_judge.sv
module pfdc_ratio_judge
    import pfdc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] good,
    input  logic [CNT_W-1:0] issued,
    input  logic [CNT_W-1:0] miss,
    input  logic [CNT_W-1:0] hit,
    input  thr_t             thr,
    output step_e            step
);
    logic [CNT_W:0] access;
    logic cov_hi, cov_lo, acc_hi, acc_lo, hr_hi, hr_lo;
    logic go_up, go_down;

    assign access = {1'b0, hit} + {1'b0, miss};

    always_comb begin
        cov_hi = ratio_above(32'(good), 32'(miss),   thr.cov_hi);
        cov_lo = ratio_below(32'(good), 32'(miss),   thr.cov_lo);
        acc_hi = ratio_above(32'(good), 32'(issued), thr.acc_hi);
        acc_lo = ratio_below(32'(good), 32'(issued), thr.acc_lo);
        hr_hi  = ratio_above(32'(hit),  32'(access), thr.hit_hi);
        hr_lo  = ratio_below(32'(hit),  32'(access), thr.hit_lo);

        go_up   = cov_hi && (acc_hi || hr_lo);
        go_down = (cov_lo && (acc_lo || hr_hi)) || (acc_lo && hr_hi);

        if (go_up)        step = STEP_UP;     // R4 priority
        else if (go_down) step = STEP_DOWN;   // R5
        else              step = STEP_HOLD;
    end

    // R6: no data at all gives no step
    always_comb begin
        if (miss == '0 && issued == '0 && hit == '0)
            assert_empty_epoch_hold_R6: assert (step == STEP_HOLD);
    end

endmodule

// File: rtl/pfdc_degree_calc.sv
module pfdc_degree_calc
    import pfdc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int EPOCH_W   = 16,
    parameter int LAT_W     = 12,
    parameter int MAX_DEG   = 16,
    parameter int START_DEG = 4,
    parameter int DEG_W     = $clog2(MAX_DEG + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strobe,
    input  step_e              step,
    input  logic [CNT_W-1:0]   good,
    input  logic [CNT_W-1:0]   issued,
    input  logic [CNT_W-1:0]   miss,
    input  logic [EPOCH_W-1:0] epoch_len,
    input  logic [LAT_W-1:0]   mem_lat,
    output logic [DEG_W-1:0]   degree
);
    localparam int REQ_W  = CNT_W + 1;
    localparam int DEM_W  = REQ_W + LAT_W;
    localparam int PROD_W = DEM_W + EPOCH_W + DEG_W;
    localparam logic [DEG_W-1:0] DEG_MAX   = DEG_W'(MAX_DEG);
    localparam logic [DEG_W-1:0] DEG_START = DEG_W'(START_DEG);

    logic [DEG_W-1:0]   useful, useful_nx, degree_nx;
    logic [REQ_W-1:0]   offered, req;
    logic [DEM_W-1:0]   demand;
    logic [EPOCH_W-1:0] len_eff;
    logic [MAX_DEG-1:0] fits;

    // step with saturation at 1 and MAX_DEG
    always_comb begin
        unique case (step)
            STEP_UP:   useful_nx = (useful >= DEG_MAX) ? DEG_MAX : useful + 1'b1;
            STEP_DOWN: useful_nx = (useful <= DEG_W'(1)) ? DEG_W'(1) : useful - 1'b1;
            default:   useful_nx = useful;
        endcase
    end

    // request estimate, clamped at zero
    assign offered = {1'b0, miss} + {1'b0, issued};
    assign req     = (offered > REQ_W'(good)) ? offered - REQ_W'(good) : '0;
    assign demand  = DEM_W'(req) * DEM_W'(mem_lat);
    assign len_eff = (epoch_len == '0) ? EPOCH_W'(1) : epoch_len;

    // min(floor(demand/len), useful_nx) = number of k <= useful_nx with k*len <= demand
    for (genvar k = 1; k <= MAX_DEG; k++) begin : g_fit
        logic [PROD_W-1:0] k_len;
        assign k_len      = PROD_W'(k) * PROD_W'(len_eff);
        assign fits[k-1]  = (k_len <= PROD_W'(demand)) && (DEG_W'(k) <= useful_nx);
    end

    assign degree_nx = DEG_W'($countones(fits));

    always_ff @(posedge clk) begin
        if (rst) begin
            useful <= DEG_START;
            degree <= DEG_START;
        end else if (strobe) begin
            useful <= useful_nx;
            degree <= degree_nx;
        end
    end

    // R7: useful degree stays inside its limits
    assert_useful_range_R7: assert property (@(posedge clk) disable iff (rst)
        (useful >= DEG_W'(1)) && (useful <= DEG_MAX));

    // R2: the degree only moves right after a boundary
    assert_degree_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(strobe) |-> $stable(degree));

    // R9: the effective degree never exceeds the useful degree once updated
    assert_degree_capped_R9: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (degree <= useful));

    // R4: an upward step never lowers the useful degree
    assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
        strobe && step == STEP_UP |=> (useful >= $past(useful)));

    // R5: a downward step never raises the useful degree
    assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
        strobe && step == STEP_DOWN |=> (useful <= $past(useful)));

endmodule

// File: rtl/pf_degree_ctrl.sv
module pf_degree_ctrl
    import pfdc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int EPOCH_W   = 16,
    parameter int LAT_W     = 12,
    parameter int MAX_DEG   = 16,
    parameter int START_DEG = 4,
    parameter int DEG_W     = $clog2(MAX_DEG + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_good,
    input  logic               ev_issued,
    input  logic               ev_miss,
    input  logic               ev_hit,
    input  logic [THR_W-1:0]   thr_cov_hi,
    input  logic [THR_W-1:0]   thr_cov_lo,
    input  logic [THR_W-1:0]   thr_acc_hi,
    input  logic [THR_W-1:0]   thr_acc_lo,
    input  logic [THR_W-1:0]   thr_hit_hi,
    input  logic [THR_W-1:0]   thr_hit_lo,
    input  logic [EPOCH_W-1:0] epoch_len,
    input  logic [LAT_W-1:0]   mem_lat,
    output logic [DEG_W-1:0]   degree
);
    localparam int N_EV = 4;

    logic             strobe;
    ev_t              ev;
    thr_t             thr;
    step_e            step;
    logic [CNT_W-1:0] cnt [N_EV];
    logic [N_EV-1:0]  ev_vec;

    assign ev     = '{good: ev_good, issued: ev_issued, miss: ev_miss, hit: ev_hit};
    assign ev_vec = ev;   // bit 3 good, 2 issued, 1 miss, 0 hit
    assign thr    = '{cov_hi: thr_cov_hi, cov_lo: thr_cov_lo,
                      acc_hi: thr_acc_hi, acc_lo: thr_acc_lo,
                      hit_hi: thr_hit_hi, hit_lo: thr_hit_lo};

    pfdc_epoch_timer #(.EPOCH_W(EPOCH_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .epoch_len (epoch_len),
        .strobe    (strobe)
    );

    for (genvar i = 0; i < N_EV; i++) begin : g_cnt
        pfdc_evt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clear (strobe),
            .inc   (ev_vec[i]),
            .count (cnt[i])
        );
    end

    pfdc_ratio_judge #(.CNT_W(CNT_W)) u_judge (
        .good   (cnt[3]),
        .issued (cnt[2]),
        .miss   (cnt[1]),
        .hit    (cnt[0]),
        .thr    (thr),
        .step   (step)
    );

    pfdc_degree_calc #(
        .CNT_W     (CNT_W),
        .EPOCH_W   (EPOCH_W),
        .LAT_W     (LAT_W),
        .MAX_DEG   (MAX_DEG),
        .START_DEG (START_DEG),
        .DEG_W     (DEG_W)
    ) u_deg (
        .clk       (clk),
        .rst       (rst),
        .strobe    (strobe),
        .step      (step),
        .good      (cnt[3]),
        .issued    (cnt[2]),
        .miss      (cnt[1]),
        .epoch_len (epoch_len),
        .mem_lat   (mem_lat),
        .degree    (degree)
    );

endmodule

// File: tb/pf_degree_ctrl_tb.sv
`timescale 1ns/1ps
module pf_degree_ctrl_tb;

    localparam int MAX_DEG   = 16;
    localparam int START_DEG = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_good = 0, ev_issued = 0, ev_miss = 0, ev_hit = 0;
    logic [10:0] thr_cov_hi = 11'd512, thr_cov_lo = 11'd256;
    logic [10:0] thr_acc_hi = 11'd768, thr_acc_lo = 11'd256;
    logic [10:0] thr_hit_hi = 11'd768, thr_hit_lo = 11'd256;
    logic [15:0] epoch_len = 16'd8;
    logic [11:0] mem_lat = 12'd100;
    logic [4:0]  degree;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    int m_ep = 0;
    int m_cnt [4];       // good, issued, miss, hit
    int m_u = START_DEG;
    int m_deg = START_DEG;

    always #4 clk = ~clk;

    pf_degree_ctrl #(.MAX_DEG(MAX_DEG), .START_DEG(START_DEG)) u_dut (
        .clk(clk), .rst(rst),
        .ev_good(ev_good), .ev_issued(ev_issued), .ev_miss(ev_miss), .ev_hit(ev_hit),
        .thr_cov_hi(thr_cov_hi), .thr_cov_lo(thr_cov_lo),
        .thr_acc_hi(thr_acc_hi), .thr_acc_lo(thr_acc_lo),
        .thr_hit_hi(thr_hit_hi), .thr_hit_lo(thr_hit_lo),
        .epoch_len(epoch_len), .mem_lat(mem_lat), .degree(degree)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: degree actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit above(longint n, longint d, longint t);
        return (d != 0) && (n * 1024 > t * d);
    endfunction

    function automatic bit below(longint n, longint d, longint t);
        return (d != 0) && (n * 1024 < t * d);
    endfunction

    // expected boundary decision from the requirements
    function automatic void epoch_decide();
        longint g = m_cnt[0], t = m_cnt[1], mi = m_cnt[2], h = m_cnt[3];
        longint req, bw, len;
        bit cv_h, cv_l, ac_h, ac_l, ht_h, ht_l;
        cv_h = above(g, mi, thr_cov_hi);
        cv_l = below(g, mi, thr_cov_lo);
        ac_h = above(g, t, thr_acc_hi);
        ac_l = below(g, t, thr_acc_lo);
        ht_h = above(h, h + mi, thr_hit_hi);
        ht_l = below(h, h + mi, thr_hit_lo);
        if (cv_h && (ac_h || ht_l))
            m_u = (m_u < MAX_DEG) ? m_u + 1 : MAX_DEG;
        else if ((cv_l && (ac_l || ht_h)) || (ac_l && ht_h))
            m_u = (m_u > 1) ? m_u - 1 : 1;
        req = mi + t - g;
        if (req < 0) req = 0;
        len = (epoch_len == 0) ? 1 : longint'(epoch_len);
        bw  = (req * longint'(mem_lat)) / len;
        m_deg = (bw < m_u) ? int'(bw) : m_u;
    endfunction

    // one cycle: check at the negedge, drive, then advance the model
    task automatic cycle(string tag, int pg, int pi, int pm, int ph);
        bit e [4];
        bit strobe;
        check(tag, degree, m_deg);
        e[0] = ($urandom_range(0, 99) < pg);
        e[1] = ($urandom_range(0, 99) < pi);
        e[2] = ($urandom_range(0, 99) < pm);
        e[3] = ($urandom_range(0, 99) < ph);
        ev_good = e[0]; ev_issued = e[1]; ev_miss = e[2]; ev_hit = e[3];
        strobe = (m_ep + 1 >= int'(epoch_len));
        if (strobe) begin
            epoch_decide();
            for (int i = 0; i < 4; i++) m_cnt[i] = e[i];
            m_ep = 0;
        end else begin
            for (int i = 0; i < 4; i++) m_cnt[i] += e[i];
            m_ep++;
        end
        @(negedge clk);
    endtask

    task automatic phase(string tag, int n, int len, int lat, int pg, int pi, int pm, int ph);
        epoch_len = 16'(len);
        mem_lat   = 12'(lat);
        for (int c = 0; c < n; c++) cycle(tag, pg, pi, pm, ph);
    endtask

    initial begin
        void'($urandom(32'd20240613));
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", degree, START_DEG);
        rst = 1'b0;
        // first cycle after reset, before any boundary with epoch_len 8
        phase("R1 R2 start", 4, 8, 100, 0, 0, 0, 0);
        phase("R6 empty epochs", 40, 8, 100, 0, 0, 0, 0);
        phase("R4 R7 ramp up", 420, 16, 200, 60, 60, 60, 5);
        phase("R5 R7 ramp down", 420, 16, 200, 0, 50, 10, 80);
        phase("R4 regain", 200, 16, 200, 60, 60, 60, 5);
        phase("R8 clamp", 120, 12, 4000, 50, 0, 0, 0);
        phase("R9 cap", 400, 64, 40, 30, 30, 30, 20);
        phase("R9 cap small lat", 300, 32, 3, 40, 40, 40, 10);
        phase("R2 len0", 60, 0, 50, 40, 40, 40, 40);
        phase("R2 len1", 60, 1, 50, 40, 40, 40, 40);
        phase("R2 R3 len2", 60, 2, 50, 50, 50, 50, 50);
        for (int p = 0; p < 24; p++) begin
            thr_cov_hi = 11'($urandom_range(100, 1024));
            thr_cov_lo = 11'($urandom_range(0, 600));
            thr_acc_hi = 11'($urandom_range(100, 1024));
            thr_acc_lo = 11'($urandom_range(0, 600));
            thr_hit_hi = 11'($urandom_range(100, 1024));
            thr_hit_lo = 11'($urandom_range(0, 600));
            phase("R3 R4 R5 R9 random", 500, $urandom_range(2, 50), $urandom_range(1, 300),
                  $urandom_range(0, 90), $urandom_range(0, 90),
                  $urandom_range(0, 90), $urandom_range(0, 90));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule